// File: doc/BRIEF.md
# Fetch-Driven Refresh Counter

This block is an 8-bit special register that counts instruction fetch cycles. Its value is meant to go onto the low half of the address bus during the refresh slot of an opcode fetch, so that dynamic memory rows are swept in turn. Only the low 7 bits count. The top bit holds whatever software last wrote.

The fetch sequencer asserts `strobe_i` for every bus read. It marks opcode and prefix-byte reads with `opcode_i`. Operand and data reads leave `opcode_i` low and do not advance the counter. Software can load all 8 bits through `load_i` and `load_data_i`, and reads the register on `value_o`. When the 7-bit field rolls over from its maximum value to zero, `wrap_o` pulses for one cycle. That pulse can be used as an interrupt source.

Top module: `refresh_ctr`

## Requirements
- R1: While `rst_ni` is low, `value_o` is 0x00 and `wrap_o` is 0.
- R2: A cycle with `strobe_i`=1, `opcode_i`=1 and `load_i`=0 adds one to `value_o[6:0]` at that clock edge.
- R3: Prefix bytes are fetched as opcode cycles, so back-to-back opcode strobes on consecutive cycles each advance the field by one.
- R4: The counting field wraps from 127 to 0.
- R5: Counting never changes `value_o[7]`. Bit 7 keeps the value last loaded.
- R6: A cycle with `load_i`=1 writes all 8 bits of `load_data_i`, including bit 7, into the register at that edge.
- R7: When a load and an opcode strobe arrive in the same cycle, the load value is taken and no increment is applied.
- R8: `wrap_o` is 1 for exactly the one cycle after an increment that takes the field from 127 to 0. It stays 0 after any load, including a load of a zero field.
- R9: A cycle with `strobe_i`=0, or with `strobe_i`=1 and `opcode_i`=0, and with `load_i`=0, leaves `value_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Bus read strobe from the fetch sequencer |
| opcode_i | input | 1 | Marks the current read as an opcode or prefix fetch |
| load_i | input | 1 | Software write enable |
| load_data_i | input | 8 | Software write data |
| value_o | output | 8 | Register value, also used as the refresh row address |
| wrap_o | output | 1 | One-cycle pulse after the counting field rolls over |

## Verification
The bench loads each of the 256 possible byte values in turn. Each load arrives together with an opcode strobe, which exercises the load-over-fetch priority. After each load the bench runs 140 cycles that repeat a fixed five-cycle pattern:
- three consecutive opcode fetches, modelling prefix chains;
- one operand read;
- one idle cycle.

Starting from every value means that the rollover from 127 to 0 is crossed with both settings of bit 7. It also means that loads of a zero field are seen without a wrap pulse. The operand and idle slots separate a design that counts all strobes from one that counts only opcode fetches. The model in the bench computes every expected value arithmetically, modulo 128 on the low field.

// File: rtl/refresh_ctr_pkg.sv
package refresh_ctr_pkg;
  typedef enum logic [1:0] {
    RC_HOLD = 2'd0,
    RC_LOAD = 2'd1,
    RC_STEP = 2'd2
  } rc_op_e;
endpackage

// File: rtl/refresh_ctr_dec.sv
module refresh_ctr_dec
  import refresh_ctr_pkg::*;
(
  input  logic   strobe_i,
  input  logic   opcode_i,
  input  logic   load_i,
  output rc_op_e op_o
);
  // software write has priority over a fetch in the same cycle
  always_comb begin
    if (load_i)                    op_o = RC_LOAD;
    else if (strobe_i && opcode_i) op_o = RC_STEP;
    else                           op_o = RC_HOLD;
  end
endmodule

// File: rtl/refresh_ctr_inc.sv
module refresh_ctr_inc #(
  parameter int unsigned REG_W = 8
) (
  input  logic [REG_W-1:0] cur_i,
  output logic [REG_W-1:0] nxt_o,
  output logic             carry_o
);
  localparam int unsigned CNT_W = REG_W - 1;

  logic [CNT_W-1:0] field;
  assign field   = cur_i[CNT_W-1:0];
  assign carry_o = &field;
  // top bit bypasses the adder
  assign nxt_o   = {cur_i[REG_W-1], field + CNT_W'(1)};
endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr
  import refresh_ctr_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             opcode_i,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_data_i,
  output logic [REG_W-1:0] value_o,
  output logic             wrap_o
);
  rc_op_e           op;
  logic [REG_W-1:0] value_q;
  logic [REG_W-1:0] inc_val;
  logic             inc_carry;
  logic             wrap_q;

  refresh_ctr_dec u_dec (
    .strobe_i (strobe_i),
    .opcode_i (opcode_i),
    .load_i   (load_i),
    .op_o     (op)
  );

  refresh_ctr_inc #(.REG_W(REG_W)) u_inc (
    .cur_i   (value_q),
    .nxt_o   (inc_val),
    .carry_o (inc_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= (op == RC_STEP) && inc_carry;
      unique case (op)
        RC_LOAD: value_q <= load_data_i;
        RC_STEP: value_q <= inc_val;
        default: value_q <= value_q;
      endcase
    end
  end

  assign value_o = value_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/refresh_ctr_chk.sv
module refresh_ctr_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strobe_i,
  input logic             opcode_i,
  input logic             load_i,
  input logic [REG_W-1:0] load_data_i,
  input logic [REG_W-1:0] value_o,
  input logic             wrap_o
);
  localparam int unsigned CNT_W = REG_W - 1;

  logic step;
  assign step = strobe_i && opcode_i && !load_i;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> value_o[CNT_W-1:0] == CNT_W'($past(value_o[CNT_W-1:0]) + 1'b1));

  a_r5_top_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> value_o[REG_W-1] == $past(value_o[REG_W-1]));

  // R7: load taken even with a fetch present
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> value_o == $past(load_data_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(strobe_i && opcode_i)) |=> $stable(value_o));

  a_r8_wrap_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (&value_o[CNT_W-1:0])) |=> wrap_o);

  a_r8_wrap_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> value_o[CNT_W-1:0] == '0 && !$past(load_i));

  a_r1_reset: assert property (@(posedge clk_i)
    !rst_ni |-> value_o == '0 && !wrap_o);
endmodule

bind refresh_ctr refresh_ctr_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_refresh_ctr.sv
module tb_refresh_ctr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic       opcode_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_data_i = 8'h00;
  logic [7:0] value_o;
  logic       wrap_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_val = 8'h00;
  logic       m_wrap = 1'b0;

  always #2 clk_i = ~clk_i;

  refresh_ctr dut (.*);

  task automatic check(input string tag, input logic [7:0] v, input logic w);
    n_chk++;
    if (value_o !== v || wrap_o !== w) begin
      n_fail++;
      $display("FAIL %s: value=%02h wrap=%0b expected value=%02h wrap=%0b",
               tag, value_o, wrap_o, v, w);
    end
  endtask

  task automatic cycle(input logic s, input logic o, input logic l, input logic [7:0] d);
    string tag;
    @(negedge clk_i);
    strobe_i = s; opcode_i = o; load_i = l; load_data_i = d;
    if (l) begin
      tag = (s && o) ? "R7" : "R6";
      m_val = d; m_wrap = 1'b0;
    end else if (s && o) begin
      m_wrap = (m_val[6:0] == 7'h7f);
      tag = m_wrap ? "R4 R5 R8" : "R2 R3 R5";
      m_val = {m_val[7], 7'(m_val[6:0] + 7'd1)};
    end else begin
      tag = "R9"; m_wrap = 1'b0;
    end
    @(posedge clk_i); #1;
    check(tag, m_val, m_wrap);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: value=%02h wrap=%0b expected run to finish", value_o, wrap_o);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    #7;
    check("R1", 8'h00, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int v = 0; v < 256; v++) begin
      cycle(1'b1, 1'b1, 1'b1, 8'(v));
      for (int k = 0; k < 140; k++) begin
        case (k % 5)
          0, 1, 2: cycle(1'b1, 1'b1, 1'b0, 8'h00);
          3:       cycle(1'b1, 1'b0, 1'b0, 8'h00);
          default: cycle(1'b0, 1'b1, 1'b0, 8'h00);
        endcase
      end
      cycle(1'b0, 1'b0, 1'b1, {8'(v)} ^ 8'h80);
    end
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R1", 8'h00, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule